// File: doc/BRIEF.md
# Synchronous DRAM Access Controller

This block sits between a simple host port and one 16 Mbit synchronous DRAM. The DRAM has two banks, each 2048 rows by 256 columns of 16-bit words. The host presents one word request at a time. Each request carries a flat 20-bit word address, a write flag, write data and two byte enables, and uses a valid/ready handshake. The controller splits the address into bank, row and column. It opens the row with an activate command and then issues a single-word read or write with auto precharge, so the device closes the row by itself. For reads, it captures the returning word exactly CAS latency clocks after the read command and pulses a read-valid strobe.

After reset the controller runs the power-up sequence before it accepts any request. It holds CKE low for a programmable delay, then issues precharge-all, then a programmable number of auto refreshes, then a mode-register load. From then on, an interval timer raises refresh requests. A pending refresh is served as soon as the current access has finished and before any new host request. Every timing constraint is a parameter counted in clocks. Every wait cycle carries an explicit NOP.

Top module: `sdr_ctrl_top`

## Requirements
- R1: The word address splits as bank = addr[19], row = addr[18:8], column = addr[7:0]. The activate carries the bank on the bank pin and the row on address bits 10:0. The following read or write carries the same bank, the column on address bits 7:0, and address bit 10 set to request auto precharge.
- R2: After reset CKE is low, the command is NOP and req_ready is low. The first command that is not a NOP is a precharge-all (address bit 10 set), issued no sooner than T_INIT cycles after reset is released and with CKE high. At least INIT_REFS auto refreshes follow. Then comes a mode-register load whose address word holds CAS_LAT in bits 6:4, 0 (linear order) in bit 3, 000 (burst of one) in bits 2:0, and zeros elsewhere. req_ready stays low until that load is issued, and no activate comes before it.
- R3: A read or write is issued only while a row is open, and no sooner than T_RCD cycles after its activate.
- R4: For every read command, rd_valid pulses for exactly one cycle, CAS_LAT+1 cycles after the cycle in which the read command appears on the pins. rd_data then holds the word the device drove at the end of the CAS latency. Reads return in request order.
- R5: During a write command the controller drives sd_dq_out with the request data and sets sd_dq_oe. sd_dqm[0] masks the low byte and sd_dqm[1] masks the high byte, each as the inverse of the matching byte enable. sd_dq_oe is low in every other cycle.
- R6: After the power-up sequence no explicit precharge is ever issued, and two activates are at least T_RC cycles apart.
- R7: A pending refresh is served before any new host request. Once the power-up sequence is done, consecutive auto refreshes are never more than REF_INTERVAL + T_RFC + T_RCD + T_RC + T_WR + T_RP + CAS_LAT cycles apart, even under continuous host load.
- R8: For T_RFC cycles after an auto refresh, only NOP commands are issued.
- R9: A request is accepted on a cycle with req_valid and req_ready both high. Each accepted request produces exactly one activate, in the next cycle, followed by one access of the requested type. req_ready is low from acceptance until that access has finished.
- R10: Every cycle without a command carries NOP. The command pins use these encodings, written as {cs_n, ras_n, cas_n, we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000. The chip is never deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the DRAM |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Flat word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| rd_valid | output | 1 | One-cycle strobe per returned read word |
| rd_data | output | 16 | Returned read word |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Multiplexed row / column address |
| sd_dqm | output | 2 | Byte masks, bit 0 = low byte |
| sd_dq_out | output | 16 | Data driven toward the DRAM |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The bench builds the controller with CAS_LAT = 3, the deepest capture delay, so the exact return cycle is tested at its longest pipeline. It shortens T_INIT to 20 clocks and REF_INTERVAL to 50 clocks. With these values the whole power-up sequence and dozens of refreshes fit in a short run, and refresh requests collide often with back-to-back host traffic. T_RC = 7 is larger than T_RCD plus the write recovery path, so activate spacing is governed by the row cycle limit. Address corners at both ends and at the bank boundary, and every byte-enable pattern, are run through a behavioural DRAM model that checks timing and returns data on the programmed latency.

// File: rtl/sdr_ctrl_pkg.sv
package sdr_ctrl_pkg;

    localparam int BANK_W = 1;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;
    localparam int DATA_W = 16;
    localparam int MASK_W = DATA_W / 8;
    // address pin that requests auto precharge / precharge-all
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_ACT  = 4'b0011,
        CMD_RD   = 4'b0101,
        CMD_WR   = 4'b0100,
        CMD_PRE  = 4'b0010,
        CMD_REF  = 4'b0001,
        CMD_MRS  = 4'b0000
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PRE_ALL,
        ST_INIT_REF,
        ST_MODE,
        ST_IDLE,
        ST_ACCESS
    } seq_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } sdr_loc_t;

    typedef struct packed {
        logic              we;
        sdr_loc_t          loc;
        logic [DATA_W-1:0] wdata;
        logic [MASK_W-1:0] be;
    } host_req_t;

    function automatic sdr_loc_t split_addr(input logic [ADDR_W-1:0] a);
        return sdr_loc_t'(a);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // burst of one, linear order, latency in bits 6:4
    function automatic logic [ROW_W-1:0] mode_word(input int cl);
        logic [ROW_W-1:0] w;
        w      = '0;
        w[6:4] = 3'(cl);
        return w;
    endfunction

    // cycles from a read/write command until the next command may be issued
    function automatic int post_access_wait(input int rc, input int rcd,
                                            input int wr, input int rp,
                                            input int cl);
        return imax(rc - rcd, imax(wr + rp, cl + 1));
    endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(REF_INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tick_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            pend     <= 1'b0;
        end else begin
            if (tick_cnt == LAST) begin
                tick_cnt <= '0;
                pend     <= 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
                if (ack) pend <= 1'b0;
            end
        end
    end

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issued,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] lat_pipe;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) lat_pipe <= '0;
                else     lat_pipe <= rd_issued;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) lat_pipe <= '0;
                else     lat_pipe <= {lat_pipe[CAS_LAT-2:0], rd_issued};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= lat_pipe[CAS_LAT-1];
            if (lat_pipe[CAS_LAT-1]) rd_data <= dq_in;
        end
    end

    // R4
    one_beat_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq
    import sdr_ctrl_pkg::*;
#(
    parameter int CAS_LAT   = 2,
    parameter int T_INIT    = 20000,
    parameter int T_RP      = 2,
    parameter int T_RCD     = 2,
    parameter int T_RC      = 7,
    parameter int T_RFC     = 7,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int INIT_REFS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  host_req_t         req,
    output logic              req_ready,
    input  logic              ref_pend,
    output logic              ref_ack,
    output sdr_cmd_e          cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [MASK_W-1:0] dqm_o,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              cke_o
);
    localparam int T_POST  = post_access_wait(T_RC, T_RCD, T_WR, T_RP, CAS_LAT);
    localparam int CNT_MAX = imax(T_INIT, imax(T_POST, imax(T_RFC,
                             imax(T_RP, imax(T_RCD, T_MRD)))));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int IR_W    = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] AP_MASK = ROW_W'(1) << AP_BIT;

    seq_state_e       st;
    logic [CNT_W-1:0] wait_cnt;
    logic [IR_W-1:0]  init_left;
    host_req_t        cur;
    logic             slot_free;

    assign slot_free = (st == ST_IDLE) && (wait_cnt == '0);
    assign req_ready = slot_free && !ref_pend;
    assign ref_ack   = slot_free && ref_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_POWERUP;
            wait_cnt  <= CNT_W'(T_INIT - 1);
            init_left <= IR_W'(INIT_REFS - 1);
            cur       <= '0;
            cmd_o     <= CMD_NOP;
            ba_o      <= '0;
            addr_o    <= '0;
            dqm_o     <= '0;
            dq_o      <= '0;
            dq_oe_o   <= 1'b0;
            cke_o     <= 1'b0;
        end else begin
            cmd_o   <= CMD_NOP;
            dq_oe_o <= 1'b0;
            dqm_o   <= '0;
            if (wait_cnt != '0) begin
                wait_cnt <= wait_cnt - 1'b1;
            end else begin
                unique case (st)
                    ST_POWERUP: begin
                        cke_o <= 1'b1;
                        st    <= ST_PRE_ALL;
                    end
                    ST_PRE_ALL: begin
                        cmd_o    <= CMD_PRE;
                        addr_o   <= AP_MASK;
                        wait_cnt <= CNT_W'(T_RP - 1);
                        st       <= ST_INIT_REF;
                    end
                    ST_INIT_REF: begin
                        cmd_o    <= CMD_REF;
                        wait_cnt <= CNT_W'(T_RFC - 1);
                        if (init_left == '0) st <= ST_MODE;
                        else                 init_left <= init_left - 1'b1;
                    end
                    ST_MODE: begin
                        cmd_o    <= CMD_MRS;
                        ba_o     <= '0;
                        addr_o   <= mode_word(CAS_LAT);
                        wait_cnt <= CNT_W'(T_MRD - 1);
                        st       <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (ref_pend) begin
                            cmd_o    <= CMD_REF;
                            wait_cnt <= CNT_W'(T_RFC - 1);
                        end else if (req_valid) begin
                            cur      <= req;
                            cmd_o    <= CMD_ACT;
                            ba_o     <= req.loc.bank;
                            addr_o   <= req.loc.row;
                            wait_cnt <= CNT_W'(T_RCD - 1);
                            st       <= ST_ACCESS;
                        end
                    end
                    ST_ACCESS: begin
                        cmd_o    <= cur.we ? CMD_WR : CMD_RD;
                        ba_o     <= cur.loc.bank;
                        addr_o   <= ROW_W'(cur.loc.col) | AP_MASK;
                        wait_cnt <= CNT_W'(T_POST - 1);
                        st       <= ST_IDLE;
                        if (cur.we) begin
                            dq_oe_o <= 1'b1;
                            dq_o    <= cur.wdata;
                            dqm_o   <= ~cur.be;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // ---------------- protocol checks on the issued command stream ----------
    localparam int AW = $clog2(T_RC + 1);
    localparam int FW = $clog2(T_RFC + 1);
    logic [AW-1:0] since_act;
    logic [FW-1:0] since_ref;
    logic          mode_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= AW'(T_RC);
            since_ref <= FW'(T_RFC);
            mode_done <= 1'b0;
        end else begin
            if (cmd_o == CMD_ACT)           since_act <= AW'(1);
            else if (since_act != AW'(T_RC)) since_act <= since_act + 1'b1;
            if (cmd_o == CMD_REF)            since_ref <= FW'(1);
            else if (since_ref != FW'(T_RFC)) since_ref <= since_ref + 1'b1;
            if (cmd_o == CMD_MRS) mode_done <= 1'b1;
        end
    end

    // R6
    act_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_ACT) |-> (since_act >= AW'(T_RC)));

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> (since_act >= AW'(T_RCD)));

    // R8
    rfc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (since_ref < FW'(T_RFC)) |-> (cmd_o == CMD_NOP));

    // R1
    auto_pre_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_RD || cmd_o == CMD_WR) |-> addr_o[AP_BIT]);

    // R9
    accept_act_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_o == CMD_ACT));

    // R2
    ready_after_mode_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mode_done);

    // R5
    drive_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe_o |-> (cmd_o == CMD_WR));

endmodule

// File: rtl/sdr_ctrl_top.sv
module sdr_ctrl_top
    import sdr_ctrl_pkg::*;
#(
    parameter int CAS_LAT      = 2,
    parameter int T_INIT       = 20000,
    parameter int T_RP         = 2,
    parameter int T_RCD        = 2,
    parameter int T_RC         = 7,
    parameter int T_RFC        = 7,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2,
    parameter int INIT_REFS    = 2,
    parameter int REF_INTERVAL = 1560
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_be,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    host_req_t req;
    sdr_cmd_e  cmd;
    logic      ref_pend;
    logic      ref_ack;

    always_comb begin
        req.we    = req_we;
        req.loc   = split_addr(req_addr);
        req.wdata = req_wdata;
        req.be    = req_be;
    end

    sdr_ref_timer #(
        .REF_INTERVAL(REF_INTERVAL)
    ) i_ref_timer (
        .clk (clk),
        .rst (rst),
        .ack (ref_ack),
        .pend(ref_pend)
    );

    sdr_cmd_seq #(
        .CAS_LAT  (CAS_LAT),
        .T_INIT   (T_INIT),
        .T_RP     (T_RP),
        .T_RCD    (T_RCD),
        .T_RC     (T_RC),
        .T_RFC    (T_RFC),
        .T_MRD    (T_MRD),
        .T_WR     (T_WR),
        .INIT_REFS(INIT_REFS)
    ) i_cmd_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req      (req),
        .req_ready(req_ready),
        .ref_pend (ref_pend),
        .ref_ack  (ref_ack),
        .cmd_o    (cmd),
        .ba_o     (sd_ba),
        .addr_o   (sd_addr),
        .dqm_o    (sd_dqm),
        .dq_o     (sd_dq_out),
        .dq_oe_o  (sd_dq_oe),
        .cke_o    (sd_cke)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdr_rd_capture #(
        .CAS_LAT(CAS_LAT),
        .DATA_W (DATA_W)
    ) i_rd_capture (
        .clk      (clk),
        .rst      (rst),
        .rd_issued(cmd == CMD_RD),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/test_sdr_ctrl_top.sv
`timescale 1ns/1ps
module test_sdr_ctrl_top;

    localparam int CL   = 3;
    localparam int TI   = 20;
    localparam int TRP  = 2;
    localparam int TRCD = 2;
    localparam int TRC  = 7;
    localparam int TRFC = 6;
    localparam int TMRD = 2;
    localparam int TWR  = 2;
    localparam int NREF = 2;
    localparam int RINT = 50;
    localparam int GAP_MAX = RINT + TRFC + TRCD + TRC + TWR + TRP + CL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [0:0]  sd_ba;
    logic [10:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = '0;

    always #4 clk = ~clk;

    sdr_ctrl_top #(
        .CAS_LAT(CL), .T_INIT(TI), .T_RP(TRP), .T_RCD(TRCD), .T_RC(TRC),
        .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR), .INIT_REFS(NREF),
        .REF_INTERVAL(RINT)
    ) i_sdr_ctrl_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old_w,
                                          input logic [15:0] new_w,
                                          input logic [1:0] be);
        return {be[1] ? new_w[15:8] : old_w[15:8], be[0] ? new_w[7:0] : old_w[7:0]};
    endfunction

    // ---------------- host-side expectation ----------------
    logic [15:0] exp_mem [int];
    logic        hq_we   [$];
    logic [19:0] hq_addr [$];
    logic [15:0] hq_data [$];
    logic [1:0]  hq_be   [$];
    logic [15:0] exp_rd  [$];
    int          exp_cyc [$];

    // ---------------- behavioural DRAM model and pin checks ----------------
    logic [15:0] dev_mem [int];
    logic [15:0] sched   [int];
    int  cyc = 0;
    int  rel_cyc = -1;
    int  phase = 0;
    int  init_refs = 0;
    int  run_refs = 0;
    int  last_ref = -1000;
    int  last_act = -1000;
    int  act_cyc  = -1000;
    int  mrs_cyc  = 0;
    int  bad_nop  = 0;
    int  early_ready = 0;
    bit  row_open = 1'b0;
    logic [10:0] open_row = '0;
    logic        open_we = 1'b0;
    logic [19:0] open_addr = '0;
    logic [15:0] open_data = '0;
    logic [1:0]  open_be = '0;

    always @(negedge clk) begin
        logic [3:0] c;
        cyc++;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst) begin
            if (rel_cyc < 0) rel_cyc = cyc;
            if (phase < 2 && req_ready) early_ready++;
            // read return
            if (rd_valid) begin
                if (exp_cyc.size() == 0 || exp_rd.size() == 0) begin
                    check(1'b0, "R4 unexpected rd_valid", 32'(rd_data), 32'h0);
                end else begin
                    int ec;
                    logic [15:0] ed;
                    ec = exp_cyc.pop_front();
                    ed = exp_rd.pop_front();
                    check(cyc == ec, "R4 return cycle", 32'(cyc), 32'(ec));
                    check(rd_data == ed, "R4 return data", 32'(rd_data), 32'(ed));
                end
            end else if (exp_cyc.size() != 0 && exp_cyc[0] < cyc) begin
                check(1'b0, "R4 missing rd_valid", 32'(cyc), 32'(exp_cyc[0]));
                void'(exp_cyc.pop_front());
                if (exp_rd.size() != 0) void'(exp_rd.pop_front());
            end
            if (sd_dq_oe && c != 4'b0100) bad_nop++;
            if (c != 4'b0111) begin
                check(cyc - last_ref >= TRFC, "R8 quiet after refresh",
                      32'(cyc - last_ref), 32'(TRFC));
                case (c)
                    4'b0010: begin
                        check(phase == 0, "R6 no explicit precharge", 32'(phase), 32'h0);
                        check(sd_addr[10] == 1'b1, "R2 precharge-all bit", 32'(sd_addr), 32'h400);
                        check(cyc - rel_cyc >= TI, "R2 power-up delay",
                              32'(cyc - rel_cyc), 32'(TI));
                        check(sd_cke == 1'b1, "R2 cke high at precharge", 32'(sd_cke), 32'h1);
                        phase = 1;
                    end
                    4'b0001: begin
                        if (phase == 1) init_refs++;
                        else if (phase == 2) begin
                            if (run_refs > 0)
                                check(cyc - last_ref <= GAP_MAX, "R7 refresh gap",
                                      32'(cyc - last_ref), 32'(GAP_MAX));
                            run_refs++;
                        end else check(1'b0, "R2 refresh before precharge", 32'(phase), 32'h1);
                        last_ref = cyc;
                    end
                    4'b0000: begin
                        check(phase == 1 && init_refs >= NREF, "R2 refreshes before mode load",
                              32'(init_refs), 32'(NREF));
                        check(sd_addr == 11'(CL << 4), "R2 mode word",
                              32'(sd_addr), 32'(CL << 4));
                        phase = 2;
                        mrs_cyc = cyc;
                    end
                    4'b0011: begin
                        check(phase == 2, "R2 activate after mode load", 32'(phase), 32'h2);
                        check(cyc - last_act >= TRC, "R6 activate spacing",
                              32'(cyc - last_act), 32'(TRC));
                        if (hq_addr.size() == 0) begin
                            check(1'b0, "R9 activate without request", 32'h0, 32'h1);
                        end else begin
                            open_we   = hq_we.pop_front();
                            open_addr = hq_addr.pop_front();
                            open_data = hq_data.pop_front();
                            open_be   = hq_be.pop_front();
                            check({sd_ba, sd_addr} == open_addr[19:8], "R1 bank and row",
                                  32'({sd_ba, sd_addr}), 32'(open_addr[19:8]));
                        end
                        last_act = cyc;
                        act_cyc  = cyc;
                        row_open = 1'b1;
                        open_row = sd_addr;
                    end
                    4'b0101, 4'b0100: begin
                        int k;
                        check(row_open && (cyc - act_cyc >= TRCD), "R3 activate to access",
                              32'(cyc - act_cyc), 32'(TRCD));
                        check(sd_ba == open_addr[19] && sd_addr[7:0] == open_addr[7:0]
                              && sd_addr[10], "R1 column and auto precharge",
                              32'({sd_ba, sd_addr}), 32'({open_addr[19], 3'b100, open_addr[7:0]}));
                        check(c[0] == !open_we, "R9 access type", 32'(c), 32'(open_we));
                        k = int'({sd_ba, open_row, sd_addr[7:0]});
                        if (c == 4'b0100) begin
                            check(sd_dq_oe && sd_dq_out == open_data, "R5 write data",
                                  32'({sd_dq_oe, sd_dq_out}), 32'({1'b1, open_data}));
                            check(sd_dqm == ~open_be, "R5 byte masks",
                                  32'(sd_dqm), 32'(~open_be));
                            dev_mem[k] = merge(dev_mem.exists(k) ? dev_mem[k] : 16'h0,
                                               sd_dq_out, ~sd_dqm);
                        end else begin
                            sched[cyc + CL] = dev_mem.exists(k) ? dev_mem[k] : 16'h0;
                            exp_cyc.push_back(cyc + CL + 1);
                        end
                        row_open = 1'b0;
                    end
                    default: bad_nop++;
                endcase
            end
            sd_dq_in = sched.exists(cyc) ? sched[cyc] : 16'hBEEF;
        end
    end

    // ---------------- host driver ----------------
    task automatic host_op(input logic we, input logic [19:0] a,
                           input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        while (!req_ready) @(negedge clk);
        hq_we.push_back(we);
        hq_addr.push_back(a);
        hq_data.push_back(d);
        hq_be.push_back(be);
        if (we) exp_mem[int'(a)] = merge(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0, d, be);
        else    exp_rd.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0);
    endtask

    task automatic host_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    logic [19:0] pool [16];

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R2 R10 reset state
        check(sd_cke == 1'b0, "R2 cke low in reset", 32'(sd_cke), 32'h0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10 NOP in reset",
              32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
        check(req_ready == 1'b0, "R9 not ready in reset", 32'(req_ready), 32'h0);
        check(rd_valid == 1'b0 && sd_dq_oe == 1'b0, "R5 idle outputs in reset",
              32'({rd_valid, sd_dq_oe}), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // directed corners: address ends, bank boundary (R1)
        host_op(1'b1, 20'h00000, 16'h1111, 2'b11);
        host_op(1'b1, 20'hFFFFF, 16'h2222, 2'b11);
        host_op(1'b1, 20'h7FFFF, 16'h3333, 2'b11);
        host_op(1'b1, 20'h80000, 16'h4444, 2'b11);
        host_op(1'b0, 20'h00000, 16'h0, 2'b00);
        host_op(1'b0, 20'hFFFFF, 16'h0, 2'b00);
        host_op(1'b0, 20'h7FFFF, 16'h0, 2'b00);
        host_op(1'b0, 20'h80000, 16'h0, 2'b00);
        // byte enables (R5)
        host_op(1'b1, 20'h12345, 16'hA5A5, 2'b11);
        host_op(1'b1, 20'h12345, 16'h3C3C, 2'b01);
        host_op(1'b0, 20'h12345, 16'h0, 2'b00);
        host_op(1'b1, 20'h12345, 16'h9966, 2'b10);
        host_op(1'b0, 20'h12345, 16'h0, 2'b00);
        host_op(1'b1, 20'h12345, 16'hFFFF, 2'b00);
        host_op(1'b0, 20'h12345, 16'h0, 2'b00);
        // same bank, different rows back to back (R6)
        host_op(1'b0, 20'h00100, 16'h0, 2'b00);
        host_op(1'b0, 20'h00200, 16'h0, 2'b00);
        host_idle(2);

        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
        for (int i = 0; i < 220; i++) begin
            logic [19:0] a;
            a = pool[$urandom % 16];
            host_op(1'($urandom % 2), a, 16'($urandom), 2'($urandom));
            if ($urandom % 4 == 0) host_idle(1 + $urandom % 3);
        end
        host_idle(1);
        repeat (40) @(negedge clk);

        check(hq_addr.size() == 0, "R9 every request activated", 32'(hq_addr.size()), 32'h0);
        check(exp_cyc.size() == 0 && exp_rd.size() == 0, "R4 every read returned",
              32'(exp_rd.size()), 32'h0);
        check(bad_nop == 0, "R10 idle cycles are NOP", 32'(bad_nop), 32'h0);
        check(early_ready == 0, "R2 ready only after mode load", 32'(early_ready), 32'h0);
        check(run_refs >= (cyc - mrs_cyc) / GAP_MAX, "R7 refresh not starved",
              32'(run_refs), 32'((cyc - mrs_cyc) / GAP_MAX));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule